// File: doc/BRIEF.md
# Banked Floating-Point Register Stack

This block holds the operand registers of a floating-point unit as four independent banks of eight stack registers. Only the active bank is reachable through the stack ports. A push writes the new value to ST(0) and moves older values one position deeper. A pop frees ST(0). A relative-index read and write port addresses ST(i) of the active bank. Each register carries a valid tag. A separate debug port reads any physical slot of any bank, together with its tag.

The active bank is changed by a two-byte escape opcode presented on the opcode port. The four selector codes do not run in bank order. Bank 3 is a scratchpad that internal sequences use, but it can be selected like the others. A switch takes a fixed number of cycles, and the stack ports are stalled during that time. The register contents and tags of every bank are kept across switches. The top-of-stack pointer is a single live control field and is not saved per bank. After returning to a bank, the caller reloads a saved pointer value through the control-load input, which brings the old values back into their original stack order.

Top module: `fpbank_stack`

## Requirements
- R1: After reset the active bank is 0, the top pointer is 0, every tag of every bank is clear, and `busy_o` and `fault_o` are low.
- R2: The opcode port with `op_valid_i` high and first byte 0xDB selects a bank by its second byte: 0xE8 selects bank 0, 0xEB bank 1, 0xEA bank 2 and 0xE9 bank 3. Any other byte pair, or `op_valid_i` low, starts no switch.
- R3: An accepted switch drives `busy_o` high for exactly SWITCH_LAT (6) cycles. `bank_o` takes the new value at the edge where `busy_o` falls. A switch request made while busy is ignored.
- R4: Push, pop, write, clear and control-load commands are ignored while `busy_o` is high, and also in the cycle in which a switch is accepted.
- R5: ST(i) is physical slot (top + i) mod 8 of the active bank. A push decrements top modulo 8, stores the data in the new ST(0) and sets its tag, so the previous ST(i) becomes ST(i+1).
- R6: A pop clears the tag of ST(0) and increments top modulo 8.
- R7: A push when ST(7) is tagged, or a pop when ST(0) is untagged, changes neither top, tags nor data, and raises `fault_o` for exactly the following cycle.
- R8: A write stores data to ST(`wr_idx_i`) and sets its tag without moving top.
- R9: A clear command sets top to 0 and clears the eight tags of the active bank only. Tags and data of the other banks are unchanged.
- R10: Data and tags of a bank survive switches to other banks. The debug port returns the data and tag of any bank and physical slot.
- R11: The top pointer keeps its value across a switch. A control-load command sets it to `ctl_top_i`.
- R12: When several stack commands are raised together, only one acts, with priority clear, then control-load, then push, then pop, then write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode bytes are valid this cycle |
| op_b0_i | input | 8 | First opcode byte |
| op_b1_i | input | 8 | Second opcode byte |
| push_i | input | 1 | Push `data_i` onto the active bank |
| pop_i | input | 1 | Pop the active bank |
| wr_i | input | 1 | Write `data_i` to ST(`wr_idx_i`) |
| clr_i | input | 1 | Clear tags and top of the active bank |
| wr_idx_i | input | 3 | Relative index for writes |
| data_i | input | DATA_W | Push or write data |
| ctl_ld_i | input | 1 | Load top pointer from `ctl_top_i` |
| ctl_top_i | input | 3 | Top pointer value to load |
| rd_idx_i | input | 3 | Relative index for reads |
| rd_data_o | output | DATA_W | Data of ST(`rd_idx_i`) in the active bank |
| rd_tag_o | output | 1 | Tag of ST(`rd_idx_i`) |
| top_o | output | 3 | Current top pointer |
| bank_o | output | 2 | Active bank |
| busy_o | output | 1 | Bank switch in progress; stack ports stalled |
| fault_o | output | 1 | Stack overflow or underflow on the previous command |
| dbg_bank_i | input | 2 | Debug read bank |
| dbg_slot_i | input | 3 | Debug read physical slot |
| dbg_data_o | output | DATA_W | Debug read data |
| dbg_tag_o | output | 1 | Debug read tag |

## Verification
The properties on the top pointer assume the control-load input is low whenever a push is being checked. They also assume that no selector opcode is presented in the same cycle as a command whose result they examine. The busy-length and bank-change properties assume nothing beyond reset. The stimulus raises at most one stack command per cycle, except for one deliberate clear-with-push case. That case involves no control-load, so every premise the properties rely on stays true. Expected values are fixed in the bench from the slot arithmetic of R5, not from a model of the pointer logic.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_W    = 2;
  localparam logic [7:0]  ESC_BYTE  = 8'hDB;
  localparam logic [5:0]  SEL_HI    = 6'b111010;

  typedef logic [BANK_W-1:0] bank_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLR,
    OP_LOAD,
    OP_PUSH,
    OP_POP,
    OP_WRITE
  } stk_op_e;
endpackage

// File: rtl/fpbank_sel_dec.sv
module fpbank_sel_dec
  import fpbank_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  output logic       hit_o,
  output bank_t      bank_o
);
  assign hit_o  = valid_i && (b0_i == ESC_BYTE) && (b1_i[7:2] == SEL_HI);
  // low bits 0,1,2,3 map to banks 0,3,2,1: two's complement of the low pair
  assign bank_o = bank_t'(2'd0 - b1_i[1:0]);
endmodule

// File: rtl/fpbank_switch.sv
module fpbank_switch
  import fpbank_pkg::*;
#(
  parameter int unsigned LAT = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  bank_t bank_i,
  output logic  accept_o,
  output logic  busy_o,
  output bank_t bank_o
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  bank_t            pend_q;
  bank_t            bank_q;

  assign busy_o   = (cnt_q != '0);
  assign accept_o = req_i && !busy_o;
  assign bank_o   = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
      bank_q <= '0;
    end else if (accept_o) begin
      cnt_q  <= CNT_W'(LAT);
      pend_q <= bank_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) bank_q <= pend_q;
    end
  end
endmodule

// File: rtl/fpbank_ctrl.sv
module fpbank_ctrl
  import fpbank_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NB    = NUM_BANKS,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      push_i,
  input  logic                      pop_i,
  input  logic                      wr_i,
  input  logic                      clr_i,
  input  logic                      ld_i,
  input  logic [PW-1:0]             ld_top_i,
  input  logic [PW-1:0]             wr_idx_i,
  input  bank_t                     bank_i,
  output logic [PW-1:0]             top_o,
  output logic [NB-1:0][DEPTH-1:0]  tag_o,
  output logic                      fault_o,
  output logic                      we_o,
  output logic [PW-1:0]             we_slot_o
);
  logic [PW-1:0]            top_q, top_d;
  logic [NB-1:0][DEPTH-1:0] tag_q, tag_d;
  logic                     fault_q, fault_d;
  logic [PW-1:0]            slot_push, slot_wr;
  logic                     full, empty;
  stk_op_e                  op;

  assign slot_push = top_q - PW'(1);
  assign slot_wr   = top_q + wr_idx_i;
  assign full      = tag_q[bank_i][slot_push];
  assign empty     = !tag_q[bank_i][top_q];

  always_comb begin
    if (!en_i)       op = OP_NONE;
    else if (clr_i)  op = OP_CLR;
    else if (ld_i)   op = OP_LOAD;
    else if (push_i) op = OP_PUSH;
    else if (pop_i)  op = OP_POP;
    else if (wr_i)   op = OP_WRITE;
    else             op = OP_NONE;
  end

  always_comb begin
    top_d     = top_q;
    tag_d     = tag_q;
    fault_d   = 1'b0;
    we_o      = 1'b0;
    we_slot_o = slot_push;
    unique case (op)
      OP_CLR: begin
        tag_d[bank_i] = '0;
        top_d         = '0;
      end
      OP_LOAD: top_d = ld_top_i;
      OP_PUSH: begin
        if (full) begin
          fault_d = 1'b1;
        end else begin
          top_d                    = slot_push;
          tag_d[bank_i][slot_push] = 1'b1;
          we_o                     = 1'b1;
        end
      end
      OP_POP: begin
        if (empty) begin
          fault_d = 1'b1;
        end else begin
          tag_d[bank_i][top_q] = 1'b0;
          top_d                = top_q + PW'(1);
        end
      end
      OP_WRITE: begin
        tag_d[bank_i][slot_wr] = 1'b1;
        we_o                   = 1'b1;
        we_slot_o              = slot_wr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q   <= '0;
      tag_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      top_q   <= top_d;
      tag_q   <= tag_d;
      fault_q <= fault_d;
    end
  end

  assign top_o   = top_q;
  assign tag_o   = tag_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/fpbank_regs.sv
module fpbank_regs
  import fpbank_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NB    = NUM_BANKS,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  bank_t         we_bank_i,
  input  logic [PW-1:0] we_slot_i,
  input  logic [W-1:0]  wdata_i,
  input  bank_t         ra_bank_i,
  input  logic [PW-1:0] ra_slot_i,
  input  bank_t         rb_bank_i,
  input  logic [PW-1:0] rb_slot_i,
  output logic [W-1:0]  ra_data_o,
  output logic [W-1:0]  rb_data_o
);
  logic [W-1:0] mem_q [NB][DEPTH];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk_i) begin
        if (we_i && we_bank_i == BANK_W'(b) && we_slot_i == PW'(s))
          mem_q[b][s] <= wdata_i;
      end
    end
  end

  assign ra_data_o = mem_q[ra_bank_i][ra_slot_i];
  assign rb_data_o = mem_q[rb_bank_i][rb_slot_i];
endmodule

// File: rtl/fpbank_stack.sv
module fpbank_stack
  import fpbank_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned SWITCH_LAT = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       op_valid_i,
  input  logic [7:0]                 op_b0_i,
  input  logic [7:0]                 op_b1_i,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic                       wr_i,
  input  logic                       clr_i,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       ctl_ld_i,
  input  logic [$clog2(DEPTH)-1:0]   ctl_top_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       rd_tag_o,
  output logic [$clog2(DEPTH)-1:0]   top_o,
  output logic [1:0]                 bank_o,
  output logic                       busy_o,
  output logic                       fault_o,
  input  logic [1:0]                 dbg_bank_i,
  input  logic [$clog2(DEPTH)-1:0]   dbg_slot_i,
  output logic [DATA_W-1:0]          dbg_data_o,
  output logic                       dbg_tag_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic                            sel_hit, sw_accept, sw_busy, we;
  bank_t                           sel_bank, act_bank;
  logic [PW-1:0]                   top, we_slot, rd_slot;
  logic [NUM_BANKS-1:0][DEPTH-1:0] tags;

  fpbank_sel_dec u_dec (
    .valid_i (op_valid_i),
    .b0_i    (op_b0_i),
    .b1_i    (op_b1_i),
    .hit_o   (sel_hit),
    .bank_o  (sel_bank)
  );

  fpbank_switch #(.LAT(SWITCH_LAT)) u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (sel_hit),
    .bank_i   (sel_bank),
    .accept_o (sw_accept),
    .busy_o   (sw_busy),
    .bank_o   (act_bank)
  );

  fpbank_ctrl #(.DEPTH(DEPTH), .NB(NUM_BANKS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (!sw_busy && !sw_accept),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_i      (wr_i),
    .clr_i     (clr_i),
    .ld_i      (ctl_ld_i),
    .ld_top_i  (ctl_top_i),
    .wr_idx_i  (wr_idx_i),
    .bank_i    (act_bank),
    .top_o     (top),
    .tag_o     (tags),
    .fault_o   (fault_o),
    .we_o      (we),
    .we_slot_o (we_slot)
  );

  assign rd_slot = top + rd_idx_i;

  fpbank_regs #(.W(DATA_W), .DEPTH(DEPTH), .NB(NUM_BANKS)) u_regs (
    .clk_i     (clk_i),
    .we_i      (we),
    .we_bank_i (act_bank),
    .we_slot_i (we_slot),
    .wdata_i   (data_i),
    .ra_bank_i (act_bank),
    .ra_slot_i (rd_slot),
    .rb_bank_i (dbg_bank_i),
    .rb_slot_i (dbg_slot_i),
    .ra_data_o (rd_data_o),
    .rb_data_o (dbg_data_o)
  );

  assign rd_tag_o  = tags[act_bank][rd_slot];
  assign dbg_tag_o = tags[dbg_bank_i][dbg_slot_i];
  assign top_o     = top;
  assign bank_o    = act_bank;
  assign busy_o    = sw_busy;
endmodule

// File: rtl/fpbank_stack_chk.sv
module fpbank_stack_chk #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned SWITCH_LAT = 6,
  localparam int unsigned PW        = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [7:0]    op_b0_i,
  input logic [7:0]    op_b1_i,
  input logic          push_i,
  input logic          clr_i,
  input logic          ctl_ld_i,
  input logic [PW-1:0] top_o,
  input logic [1:0]    bank_o,
  input logic          busy_o,
  input logic          fault_o
);
  logic       sel;
  logic [7:0] run_q;

  assign sel = op_valid_i && op_b0_i == 8'hDB && (op_b1_i & 8'hFC) == 8'hE8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  AST_BANK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> $fell(busy_o)); // R3

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 8'(SWITCH_LAT)); // R3

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(top_o)); // R4

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(top_o)); // R7

  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && push_i && !clr_i && !ctl_ld_i && !sel)
      |=> (fault_o || top_o == PW'($past(top_o) - PW'(1)))); // R5

  AST_CLR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && clr_i && !sel) |=> (top_o == '0 && !fault_o)); // R9
endmodule

bind fpbank_stack fpbank_stack_chk #(.DEPTH(DEPTH), .SWITCH_LAT(SWITCH_LAT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_b0_i    (op_b0_i),
  .op_b1_i    (op_b1_i),
  .push_i     (push_i),
  .clr_i      (clr_i),
  .ctl_ld_i   (ctl_ld_i),
  .top_o      (top_o),
  .bank_o     (bank_o),
  .busy_o     (busy_o),
  .fault_o    (fault_o)
);

// File: tb/fpbank_stack_bench.sv
`timescale 1ns/1ps
module fpbank_stack_bench;
  localparam int W = 32;

  localparam int K_RDD  = 0;
  localparam int K_RDT  = 1;
  localparam int K_TOP  = 2;
  localparam int K_BANK = 3;
  localparam int K_BUSY = 4;
  localparam int K_FLT  = 5;
  localparam int K_DBD  = 6;
  localparam int K_DBT  = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [7:0]   op_b0 = '0, op_b1 = '0;
  logic         push = 1'b0, pop = 1'b0, wr = 1'b0, clr = 1'b0, ctl_ld = 1'b0;
  logic [2:0]   wr_idx = '0, ctl_top = '0, rd_idx = '0, dbg_slot = '0;
  logic [1:0]   dbg_bank = '0;
  logic [W-1:0] data = '0;
  logic [W-1:0] rd_data, dbg_data;
  logic         rd_tag, dbg_tag, busy, fault;
  logic [2:0]   top;
  logic [1:0]   bank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  fpbank_stack #(.DATA_W(W)) u_fpbank_stack (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_b0_i(op_b0), .op_b1_i(op_b1),
    .push_i(push), .pop_i(pop), .wr_i(wr), .clr_i(clr), .wr_idx_i(wr_idx), .data_i(data),
    .ctl_ld_i(ctl_ld), .ctl_top_i(ctl_top), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .rd_tag_o(rd_tag), .top_o(top), .bank_o(bank), .busy_o(busy), .fault_o(fault),
    .dbg_bank_i(dbg_bank), .dbg_slot_i(dbg_slot), .dbg_data_o(dbg_data), .dbg_tag_o(dbg_tag)
  );

  function automatic logic [63:0] observe(int k);
    case (k)
      K_RDD:   return 64'(rd_data);
      K_RDT:   return 64'(rd_tag);
      K_TOP:   return 64'(top);
      K_BANK:  return 64'(bank);
      K_BUSY:  return 64'(busy);
      K_FLT:   return 64'(fault);
      K_DBD:   return 64'(dbg_data);
      default: return 64'(dbg_tag);
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] got;
      it  = q.pop_front();
      got = observe(it.kind);
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d got=%0h exp=%0h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic expect_item(int k, logic [63:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic settle();
    wait (q.size() == 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    op_valid = 1'b0; push = 1'b0; pop = 1'b0; wr = 1'b0; clr = 1'b0; ctl_ld = 1'b0;
  endtask

  task automatic chk_state(int t, int b, int bz, int f, string r);
    expect_item(K_TOP, 64'(t), r);
    expect_item(K_BANK, 64'(b), r);
    expect_item(K_BUSY, 64'(bz), r);
    expect_item(K_FLT, 64'(f), r);
    settle();
  endtask

  task automatic chk_rd(int i, logic [W-1:0] d, int t, string r);
    rd_idx = 3'(i);
    if (t != 0) expect_item(K_RDD, 64'(d), r);
    expect_item(K_RDT, 64'(t), r);
    settle();
  endtask

  task automatic chk_dbg(int b, int s, logic [W-1:0] d, int t, string r);
    dbg_bank = 2'(b);
    dbg_slot = 3'(s);
    if (t != 0) expect_item(K_DBD, 64'(d), r);
    expect_item(K_DBT, 64'(t), r);
    settle();
  endtask

  task automatic do_push(logic [W-1:0] d);
    push = 1'b1; data = d; step();
  endtask

  task automatic do_pop();
    pop = 1'b1; step();
  endtask

  task automatic do_sel(logic [7:0] b0, logic [7:0] b1);
    op_valid = 1'b1; op_b0 = b0; op_b1 = b1; step();
  endtask

  task automatic switch_to(logic [7:0] b1);
    do_sel(8'hDB, b1);
    repeat (6) step();
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : drive
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_state(0, 0, 0, 0, "R1");
    chk_rd(0, '0, 0, "R1");
    chk_dbg(3, 5, '0, 0, "R1");

    // R5 pushes on bank 0: slots 7,6,5
    do_push(32'h11);
    do_push(32'h22);
    do_push(32'h33);
    chk_state(5, 0, 0, 0, "R5");
    chk_rd(0, 32'h33, 1, "R5");
    chk_rd(1, 32'h22, 1, "R5");
    chk_rd(2, 32'h11, 1, "R5");
    chk_rd(3, '0, 0, "R5");

    // R3/R4 switch to bank 1 with stalled pushes and an ignored second request
    do_sel(8'hDB, 8'hEB);
    chk_state(5, 0, 1, 0, "R3");
    for (int k = 0; k < 5; k++) begin
      push = 1'b1; data = 32'h55;
      if (k == 2) begin op_valid = 1'b1; op_b0 = 8'hDB; op_b1 = 8'hE8; end
      step();
      chk_state(5, 0, 1, 0, "R4");
    end
    step();
    chk_state(5, 1, 0, 0, "R3");
    chk_rd(0, '0, 0, "R11");

    // bank 1 push, then clear together with push (R12, R9)
    do_push(32'h44);
    chk_state(4, 1, 0, 0, "R5");
    chk_dbg(1, 4, 32'h44, 1, "R5");
    clr = 1'b1; push = 1'b1; data = 32'h99; step();
    chk_state(0, 1, 0, 0, "R12");
    chk_dbg(1, 4, '0, 0, "R9");
    chk_dbg(1, 7, '0, 0, "R12");
    chk_dbg(0, 7, 32'h11, 1, "R9");
    do_push(32'h66);
    chk_state(7, 1, 0, 0, "R5");

    // back to bank 0: top carried, restore saved control value (R11, R10)
    switch_to(8'hE8);
    chk_state(7, 0, 0, 0, "R11");
    chk_rd(0, 32'h11, 1, "R11");
    ctl_top = 3'd5; ctl_ld = 1'b1; step();
    chk_state(5, 0, 0, 0, "R11");
    chk_rd(0, 32'h33, 1, "R10");
    chk_rd(2, 32'h11, 1, "R10");

    // R2 non-selector opcodes
    do_sel(8'hDB, 8'hEC);
    chk_state(5, 0, 0, 0, "R2");
    do_sel(8'hD9, 8'hE8);
    chk_state(5, 0, 0, 0, "R2");
    op_b0 = 8'hDB; op_b1 = 8'hE9; step();
    chk_state(5, 0, 0, 0, "R2");

    // R8 relative writes
    wr = 1'b1; wr_idx = 3'd1; data = 32'h77; step();
    chk_state(5, 0, 0, 0, "R8");
    chk_rd(1, 32'h77, 1, "R8");
    wr = 1'b1; wr_idx = 3'd4; data = 32'h88; step();
    chk_rd(4, 32'h88, 1, "R8");
    chk_dbg(0, 1, 32'h88, 1, "R8");

    // R6 pops and R7 underflow
    do_pop();
    chk_state(6, 0, 0, 0, "R6");
    chk_rd(0, 32'h77, 1, "R6");
    chk_dbg(0, 5, '0, 0, "R6");
    do_pop();
    do_pop();
    chk_state(0, 0, 0, 0, "R6");
    do_pop();
    chk_state(0, 0, 0, 1, "R7");
    step();
    chk_state(0, 0, 0, 0, "R7");

    // R7 overflow after filling bank 0
    clr = 1'b1; step();
    for (int k = 0; k < 8; k++) do_push(32'hA0 + 32'(k));
    chk_state(0, 0, 0, 0, "R5");
    do_push(32'hBB);
    chk_state(0, 0, 0, 1, "R7");
    chk_rd(0, 32'hA7, 1, "R7");
    chk_rd(7, 32'hA0, 1, "R7");
    chk_dbg(1, 7, 32'h66, 1, "R9");

    // R2 remaining selector codes, R10 content survives
    switch_to(8'hE9);
    chk_state(0, 3, 0, 0, "R2");
    chk_rd(0, '0, 0, "R10");
    switch_to(8'hEA);
    chk_state(0, 2, 0, 0, "R2");
    chk_dbg(1, 7, 32'h66, 1, "R10");
    chk_dbg(0, 0, 32'hA7, 1, "R10");

    step();
    settle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule